// File: doc/BRIEF.md
# Quad-Word Burst Breaker with Narrow-Read Lane Replication

This block sits on the slave side of a pipelined system bus, in front of a memory that moves data only in 16-byte quad-word units. Each bus beat has an address phase and, one cycle later, a data phase. The block tracks the beat address through sequential transfers. In the data phase of the beat that finishes a quad word, it raises a burst-last flag so that the bus decoder ends the burst there. This holds whatever the start offset inside the quad word.

For reads, the block takes the 32-bit word that the memory returns for the current beat. A byte or half-word is copied onto every byte lane of the read bus. For each run of beats inside one quad word, the block emits a quad record. The record gives the quad address, a 16-bit byte mask of the bytes the run actually used, and, for writes, the merged write bytes. Bytes outside the mask are discarded on reads and masked on writes.

Top module: `quad_burst_slicer`

## Requirements
- R1: After the asynchronous reset, beat_valid_o, burst_last_o and quad_valid_o are all low.
- R2: A beat accepted with beat_seq_i low takes its address from beat_addr_i. A beat with beat_seq_i high ignores beat_addr_i and uses the previous beat's address plus a step set by the size code: 1 for code 0 (byte), 2 for code 1 (half-word), 4 for codes 2 and 3 (word). The address appears on beat_addr_o in the beat's data phase, one cycle after its address phase.
- R3: burst_last_o is high in a beat's data phase exactly when the beat's address bits [3:0] equal 0xC for a word, 0xE for a half-word or 0xF for a byte. It is low in every other cycle.
- R4: In the data phase of a half-word read, rdata_o repeats, in both 16-bit halves, the half of mem_rdata_i selected by address bit 1 (bits [31:16] when it is 1).
- R5: In the data phase of a byte read, rdata_o repeats, in all four byte lanes, the byte of mem_rdata_i at lane address[1:0] (lane n is bits 8n+7:8n).
- R6: In the data phase of a word read, rdata_o equals mem_rdata_i.
- R7: A run of beats closes at the end of the data phase of a beat that either raises burst-last or is not followed at once by a sequential beat. In the next cycle quad_valid_o pulses for one cycle. quad_addr_o then holds that beat's address bits [AW-1:4] and quad_write_o holds its direction.
- R8: quad_mask_o bit b is set exactly for the quad bytes b covered by the beats of the closed run. A beat at address bits [3:0] = a covers bytes a up to a+step-1.
- R9: For a write run, byte b of quad_wdata_o (bits 8b+7:8b) holds byte lane b mod 4 of the beat_wdata_i value that was present in the data phase of the beat covering b. Bytes not covered are zero, and a read run gives all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| beat_valid_i | input | 1 | Address phase of a beat is present |
| beat_seq_i | input | 1 | Beat continues the previous one sequentially |
| beat_addr_i | input | AW | Start address, used for non-sequential beats |
| beat_size_i | input | 2 | Size code: 0 byte, 1 half-word, 2/3 word |
| beat_write_i | input | 1 | Beat is a write |
| beat_wdata_i | input | 32 | Write data, valid in the data phase |
| mem_rdata_i | input | 32 | Memory word for the data-phase beat |
| beat_valid_o | output | 1 | A beat is in its data phase |
| beat_addr_o | output | AW | Tracked address of the data-phase beat |
| beat_size_o | output | 2 | Size code of the data-phase beat |
| beat_write_o | output | 1 | Direction of the data-phase beat |
| burst_last_o | output | 1 | Data-phase beat ends a quad word |
| rdata_o | output | 32 | Read data with narrow lanes replicated |
| quad_valid_o | output | 1 | Closed-run record is valid |
| quad_write_o | output | 1 | Closed run was a write |
| quad_addr_o | output | AW-4 | Quad-word address of the closed run |
| quad_mask_o | output | 16 | Bytes used by the closed run |
| quad_wdata_o | output | 128 | Merged write bytes of the closed run |

## Verification
Two things can happen in the same cycle. One is the close of a run, which is decided from the data-phase beat. The other is the address phase of the next transfer, which may be a fresh non-sequential start. The sweep runs back-to-back transfers with no idle cycle between them over every size, every legal start offset, lengths up to ten beats, and both directions. It repeats every case with an idle gap. In the same cycle where a new transfer's address arrives, the record of the old run is compared byte for byte against a mask and data rebuilt from the offsets. The new beat's address and burst-last are then checked in the next cycle.

// File: rtl/bbr_pkg.sv
package bbr_pkg;
  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_WRSV = 2'd3
  } size_e;

  function automatic logic [2:0] size_step(size_e s);
    case (s)
      SZ_BYTE: size_step = 3'd1;
      SZ_HALF: size_step = 3'd2;
      default: size_step = 3'd4;
    endcase
  endfunction
endpackage

// File: rtl/bbr_beat_track.sv
module bbr_beat_track
  import bbr_pkg::*;
#(
  parameter int AW = 32,
  parameter int QL = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          valid_i,
  input  logic          seq_i,
  input  logic [AW-1:0] addr_i,
  input  size_e         size_i,
  input  logic          write_i,
  output logic          dp_valid_o,
  output logic [AW-1:0] dp_addr_o,
  output size_e         dp_size_o,
  output logic          dp_write_o,
  output logic          dp_last_o
);
  logic [AW-1:0] addr_q, nxt_addr;
  logic [2:0]    stp;
  logic [QL:0]   lo_sum;
  logic          nxt_last;

  assign stp      = size_step(size_i);
  assign nxt_addr = seq_i ? addr_q + AW'(stp) : addr_i;
  // boundary beat: stepping past it carries out of the quad offset
  assign lo_sum   = {1'b0, nxt_addr[QL-1:0]} + (QL+1)'(stp);
  assign nxt_last = lo_sum[QL];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dp_valid_o <= 1'b0;
      addr_q     <= '0;
      dp_size_o  <= SZ_BYTE;
      dp_write_o <= 1'b0;
      dp_last_o  <= 1'b0;
    end else begin
      dp_valid_o <= valid_i;
      if (valid_i) begin
        addr_q     <= nxt_addr;
        dp_size_o  <= size_i;
        dp_write_o <= write_i;
        dp_last_o  <= nxt_last;
      end else begin
        dp_last_o  <= 1'b0;
      end
    end
  end

  assign dp_addr_o = addr_q;
endmodule

// File: rtl/bbr_lane_rep.sv
module bbr_lane_rep
  import bbr_pkg::*;
(
  input  logic [1:0]  addr_lo_i,
  input  size_e       size_i,
  input  logic [31:0] rdata_i,
  output logic [31:0] rdata_o
);
  logic [7:0]  sel_b;
  logic [15:0] sel_h;

  assign sel_b = rdata_i[{addr_lo_i, 3'b000} +: 8];
  assign sel_h = rdata_i[{addr_lo_i[1], 4'b0000} +: 16];

  always_comb begin
    case (size_i)
      SZ_BYTE: rdata_o = {4{sel_b}};
      SZ_HALF: rdata_o = {2{sel_h}};
      default: rdata_o = rdata_i;
    endcase
  end
endmodule

// File: rtl/bbr_quad_merge.sv
module bbr_quad_merge
  import bbr_pkg::*;
#(
  parameter int AW         = 32,
  parameter int QUAD_BYTES = 16,
  localparam int QL        = $clog2(QUAD_BYTES)
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    dp_valid_i,
  input  logic [AW-1:0]           dp_addr_i,
  input  size_e                   dp_size_i,
  input  logic                    dp_write_i,
  input  logic                    dp_last_i,
  input  logic                    cont_i,
  input  logic [31:0]             wdata_i,
  output logic                    quad_valid_o,
  output logic                    quad_write_o,
  output logic [AW-QL-1:0]        quad_addr_o,
  output logic [QUAD_BYTES-1:0]   quad_mask_o,
  output logic [8*QUAD_BYTES-1:0] quad_wdata_o
);
  logic [QUAD_BYTES-1:0]   hit, acc_mask_q;
  logic [8*QUAD_BYTES-1:0] beat_dat, acc_data_q;
  logic [QL:0]             lo_ext, hi_ext;
  logic                    close;

  assign lo_ext = {1'b0, dp_addr_i[QL-1:0]};
  assign hi_ext = lo_ext + (QL+1)'(size_step(dp_size_i));

  for (genvar b = 0; b < QUAD_BYTES; b++) begin : g_byte
    localparam int LN = b % 4;
    assign hit[b] = dp_valid_i && ((QL+1)'(b) >= lo_ext) && ((QL+1)'(b) < hi_ext);
    assign beat_dat[8*b +: 8] = (hit[b] && dp_write_i) ? wdata_i[8*LN +: 8]
                                                       : acc_data_q[8*b +: 8];
  end

  // run ends on the boundary beat or when no sequential beat follows
  assign close = dp_valid_i && (dp_last_i || !cont_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      quad_valid_o <= 1'b0;
      quad_write_o <= 1'b0;
      quad_addr_o  <= '0;
      quad_mask_o  <= '0;
      quad_wdata_o <= '0;
      acc_mask_q   <= '0;
      acc_data_q   <= '0;
    end else if (close) begin
      quad_valid_o <= 1'b1;
      quad_write_o <= dp_write_i;
      quad_addr_o  <= dp_addr_i[AW-1:QL];
      quad_mask_o  <= acc_mask_q | hit;
      quad_wdata_o <= beat_dat;
      acc_mask_q   <= '0;
      acc_data_q   <= '0;
    end else begin
      quad_valid_o <= 1'b0;
      if (dp_valid_i) begin
        acc_mask_q <= acc_mask_q | hit;
        acc_data_q <= beat_dat;
      end
    end
  end
endmodule

// File: rtl/quad_burst_slicer.sv
module quad_burst_slicer
  import bbr_pkg::*;
#(
  parameter int AW         = 32,
  parameter int QUAD_BYTES = 16,
  localparam int QL        = $clog2(QUAD_BYTES)
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    beat_valid_i,
  input  logic                    beat_seq_i,
  input  logic [AW-1:0]           beat_addr_i,
  input  logic [1:0]              beat_size_i,
  input  logic                    beat_write_i,
  input  logic [31:0]             beat_wdata_i,
  input  logic [31:0]             mem_rdata_i,
  output logic                    beat_valid_o,
  output logic [AW-1:0]           beat_addr_o,
  output logic [1:0]              beat_size_o,
  output logic                    beat_write_o,
  output logic                    burst_last_o,
  output logic [31:0]             rdata_o,
  output logic                    quad_valid_o,
  output logic                    quad_write_o,
  output logic [AW-QL-1:0]        quad_addr_o,
  output logic [QUAD_BYTES-1:0]   quad_mask_o,
  output logic [8*QUAD_BYTES-1:0] quad_wdata_o
);
  size_e dp_size;

  bbr_beat_track #(.AW(AW), .QL(QL)) u_track (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .valid_i    (beat_valid_i),
    .seq_i      (beat_seq_i),
    .addr_i     (beat_addr_i),
    .size_i     (size_e'(beat_size_i)),
    .write_i    (beat_write_i),
    .dp_valid_o (beat_valid_o),
    .dp_addr_o  (beat_addr_o),
    .dp_size_o  (dp_size),
    .dp_write_o (beat_write_o),
    .dp_last_o  (burst_last_o)
  );

  assign beat_size_o = dp_size;

  bbr_lane_rep u_rep (
    .addr_lo_i (beat_addr_o[1:0]),
    .size_i    (dp_size),
    .rdata_i   (mem_rdata_i),
    .rdata_o   (rdata_o)
  );

  bbr_quad_merge #(.AW(AW), .QUAD_BYTES(QUAD_BYTES)) u_merge (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .dp_valid_i   (beat_valid_o),
    .dp_addr_i    (beat_addr_o),
    .dp_size_i    (dp_size),
    .dp_write_i   (beat_write_o),
    .dp_last_i    (burst_last_o),
    .cont_i       (beat_valid_i && beat_seq_i),
    .wdata_i      (beat_wdata_i),
    .quad_valid_o (quad_valid_o),
    .quad_write_o (quad_write_o),
    .quad_addr_o  (quad_addr_o),
    .quad_mask_o  (quad_mask_o),
    .quad_wdata_o (quad_wdata_o)
  );
endmodule

// File: rtl/quad_burst_slicer_chk.sv
module quad_burst_slicer_chk
  import bbr_pkg::*;
#(
  parameter int AW         = 32,
  parameter int QUAD_BYTES = 16
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic                  beat_valid_i,
  input logic                  beat_seq_i,
  input logic [1:0]            beat_size_i,
  input logic                  beat_valid_o,
  input logic [AW-1:0]         beat_addr_o,
  input logic [1:0]            beat_size_o,
  input logic                  beat_write_o,
  input logic                  burst_last_o,
  input logic [31:0]           rdata_o,
  input logic                  quad_valid_o,
  input logic [QUAD_BYTES-1:0] quad_mask_o
);
  p_last_needs_beat_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    burst_last_o |-> beat_valid_o);

  p_seq_step_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (beat_valid_i && beat_seq_i && beat_valid_o && !burst_last_o) |=>
      (beat_addr_o == $past(beat_addr_o) + AW'(size_step(size_e'($past(beat_size_i))))));

  p_last_closes_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (beat_valid_o && burst_last_o) |=> quad_valid_o);

  p_close_after_beat_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    quad_valid_o |-> $past(beat_valid_o));

  p_half_repl_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (beat_valid_o && !beat_write_o && beat_size_o == 2'd1) |->
      (rdata_o[31:16] == rdata_o[15:0]));

  p_byte_repl_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (beat_valid_o && !beat_write_o && beat_size_o == 2'd0) |->
      (rdata_o == {4{rdata_o[7:0]}}));

  p_mask_set_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    quad_valid_o |-> (quad_mask_o != '0));
endmodule

bind quad_burst_slicer quad_burst_slicer_chk #(.AW(AW), .QUAD_BYTES(QUAD_BYTES)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .beat_valid_i (beat_valid_i),
  .beat_seq_i   (beat_seq_i),
  .beat_size_i  (beat_size_i),
  .beat_valid_o (beat_valid_o),
  .beat_addr_o  (beat_addr_o),
  .beat_size_o  (beat_size_o),
  .beat_write_o (beat_write_o),
  .burst_last_o (burst_last_o),
  .rdata_o      (rdata_o),
  .quad_valid_o (quad_valid_o),
  .quad_mask_o  (quad_mask_o)
);

// File: tb/tb_quad_burst_slicer.sv
`timescale 1ns/1ps
module tb_quad_burst_slicer;
  localparam int AW = 32;

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         beat_valid_i = 1'b0, beat_seq_i = 1'b0, beat_write_i = 1'b0;
  logic [31:0]  beat_addr_i = '0, beat_wdata_i = '0, mem_rdata_i = '0;
  logic [1:0]   beat_size_i = '0;
  logic         beat_valid_o, beat_write_o, burst_last_o;
  logic [31:0]  beat_addr_o, rdata_o;
  logic [1:0]   beat_size_o;
  logic         quad_valid_o, quad_write_o;
  logic [27:0]  quad_addr_o;
  logic [15:0]  quad_mask_o;
  logic [127:0] quad_wdata_o;

  always #2.5 clk_i = ~clk_i;

  quad_burst_slicer #(.AW(AW), .QUAD_BYTES(16)) dut (.*);

  int total = 0, bad = 0;

  // bench-side view of the beat in its data phase and of the pending record
  bit           r_v = 0, r_wr = 0, r_last = 0;
  logic [31:0]  r_addr = '0;
  int           r_st = 1;
  logic [1:0]   r_sz = '0;
  logic [15:0]  acc_m = '0, eq_m = '0;
  logic [127:0] acc_d = '0, eq_d = '0;
  bit           eq_v = 0, eq_wr = 0;
  logic [27:0]  eq_a = '0;

  function automatic logic [31:0] wpat(logic [31:0] a);
    return {a[7:0] ^ 8'h88, a[7:0] ^ 8'h44, a[7:0] ^ 8'h22, a[7:0] ^ 8'h11};
  endfunction

  function automatic logic [31:0] rpat(logic [31:0] a);
    return {a[7:2], 2'd3, a[7:2], 2'd2, a[7:2], 2'd1, a[7:2], 2'd0} ^ 32'h9C5A_3C96;
  endfunction

  task automatic chk(bit ok, string req, logic [127:0] act, logic [127:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cycle(bit av, bit as, logic [31:0] ta, logic [1:0] asz, bit aw);
    logic [31:0] mr, er;
    logic [15:0] hit;
    logic [127:0] nd;
    int lo, st;
    bit close;
    @(negedge clk_i);
    beat_valid_i = av;
    beat_seq_i   = as;
    beat_addr_i  = as ? ~ta : ta;   // ignored on sequential beats
    beat_size_i  = asz;
    beat_write_i = aw;
    mr = rpat(r_addr);
    mem_rdata_i  = r_v ? mr : 32'h0;
    beat_wdata_i = (r_v && r_wr) ? wpat(r_addr) : 32'h0;
    #1;
    chk(beat_valid_o == r_v, "R2 beat_valid", beat_valid_o, r_v);
    if (r_v) begin
      chk(beat_addr_o == r_addr, "R2 addr", beat_addr_o, r_addr);
      chk(burst_last_o == r_last, "R3 last", burst_last_o, r_last);
      if (!r_wr) begin
        if (r_st == 1) begin
          er = {4{mr[8*r_addr[1:0] +: 8]}};
          chk(rdata_o == er, "R5 byte repl", rdata_o, er);
        end else if (r_st == 2) begin
          er = {2{mr[16*r_addr[1] +: 16]}};
          chk(rdata_o == er, "R4 half repl", rdata_o, er);
        end else begin
          chk(rdata_o == mr, "R6 word", rdata_o, mr);
        end
      end
    end else begin
      chk(burst_last_o == 1'b0, "R3 idle last", burst_last_o, 0);
    end
    chk(quad_valid_o == eq_v, "R7 quad_valid", quad_valid_o, eq_v);
    if (eq_v) begin
      chk(quad_addr_o == eq_a, "R7 quad_addr", quad_addr_o, eq_a);
      chk(quad_write_o == eq_wr, "R7 quad_write", quad_write_o, eq_wr);
      chk(quad_mask_o == eq_m, "R8 mask", quad_mask_o, eq_m);
      chk(quad_wdata_o == eq_d, "R9 wdata", quad_wdata_o, eq_d);
    end
    // expectations for after the coming edge
    hit = '0;
    nd = acc_d;
    lo = int'(r_addr[3:0]);
    if (r_v) begin
      for (int b = 0; b < 16; b++) begin
        if (b >= lo && b < lo + r_st) begin
          hit[b] = 1'b1;
          if (r_wr) nd[8*b +: 8] = wpat(r_addr)[8*(b%4) +: 8];
        end
      end
    end
    close = r_v && (r_last || !(av && as));
    eq_v = close;
    if (close) begin
      eq_a = r_addr[31:4]; eq_wr = r_wr; eq_m = acc_m | hit; eq_d = nd;
      acc_m = '0; acc_d = '0;
    end else if (r_v) begin
      acc_m = acc_m | hit; acc_d = nd;
    end
    st = (asz == 2'd0) ? 1 : (asz == 2'd1) ? 2 : 4;
    r_v = av;
    if (av) begin
      r_addr = ta; r_wr = aw; r_st = st; r_sz = asz;
      r_last = ((int'(ta[3:0]) + st) == 16);
    end else begin
      r_last = 0;
    end
  endtask

  initial begin : watchdog
    #(200000 * 5);
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : main
    int trial;
    trial = 0;
    repeat (3) @(negedge clk_i);
    chk(beat_valid_o == 1'b0, "R1 beat_valid", beat_valid_o, 0);
    chk(burst_last_o == 1'b0, "R1 burst_last", burst_last_o, 0);
    chk(quad_valid_o == 1'b0, "R1 quad_valid", quad_valid_o, 0);
    rst_ni = 1'b1;
    for (int sz = 0; sz < 3; sz++) begin
      for (int off = 0; off < 16; off += (1 << sz)) begin
        for (int n = 1; n <= 10; n++) begin
          for (int wr = 0; wr < 2; wr++) begin
            for (int gap = 0; gap < 2; gap++) begin
              logic [31:0] base, ta;
              bit prev_last;
              base = {trial[23:0], 8'h00} + 32'h0001_0000;
              prev_last = 0;
              for (int k = 0; k < n; k++) begin
                ta = base + off + k * (1 << sz);
                cycle(1'b1, (k > 0) && !prev_last, ta, 2'(sz), wr[0]);
                prev_last = ((int'(ta[3:0]) + (1 << sz)) == 16);
              end
              if (gap == 1) cycle(1'b0, 1'b0, 32'h0, 2'd0, 1'b0);
              trial++;
            end
          end
        end
      end
    end
    repeat (3) cycle(1'b0, 1'b0, 32'h0, 2'd0, 1'b0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule